// File: doc/BRIEF.md
# Odd-Parity Contactless Frame Serializer

This block turns a stream of bytes into the serial bit sequence of one contactless-card frame. The frame opens with a single start bit. Each byte follows as eight data bits, least significant bit first, and then one odd parity bit. Bytes run back to back, and a single end bit closes the frame after the parity bit of the byte flagged as last. Bytes arrive on a valid/ready handshake with a last flag. One bit leaves on each bit-clock enable pulse, and a two-bit kind code tags it as a start, data, parity or end bit. When the next byte is late, the serializer holds the line: it emits nothing until that byte arrives.

A separate receive path takes a bit stream of data and parity bits, regroups it into nine-bit groups, recomputes odd parity and pulses an error strobe carrying the index of any byte that fails. A first-bit flag restarts the grouping and the byte index at the beginning of each frame.

The transmit controller has six states. IDLE accepts the first byte and moves to START. START emits the start bit on an enable and moves to DATA. DATA emits one data bit per enable and moves to PARITY after the eighth. PARITY emits the parity bit, then goes to END if the byte was last, back to DATA if a new byte is accepted in the same slot, or to STALL otherwise. STALL accepts the next byte and moves to DATA. END emits the end bit and returns to IDLE.

Top module: `pframe_codec`

## Requirements
- R1: After reset `in_ready` is 1, `tx_strobe` is 0 and `par_err` is 0.
- R2: Data bits of each byte leave least significant bit first, tagged with kind 1.
- R3: After each byte's eight data bits comes one parity bit, tagged with kind 2, chosen so that the nine bits hold an odd number of ones (0x60 gives parity 1).
- R4: A frame opens with exactly one start bit of value 1 (kind 0) and closes with exactly one end bit of value 0 (kind 3), right after the parity bit of the byte accepted with `in_last` set.
- R5: Kinds follow the order start, data×8, parity, data×8, parity, …, end. No delimiter sits between one parity bit and the next byte's first data bit.
- R6: `tx_strobe` pulses for one cycle only in the cycle after a cycle with `bit_en` high, and carries exactly one bit per enable. With `bit_en` low, no bit is emitted.
- R7: When a non-last byte finishes and no next byte has been accepted, no bits are emitted until a byte arrives. Emission then resumes with that byte's data bits.
- R8: `in_ready` is 1 in IDLE and STALL, and in the parity slot of a non-last byte while `bit_en` is high. It is 0 while a frame's start or data bits are pending and after a last byte.
- R9: On the ninth `rx_valid` bit of a group whose nine bits hold an even number of ones, `par_err` pulses in the next cycle with `par_err_idx` set to the zero-based byte index within the frame. `rx_first` marks the first data bit of a frame and restarts both the count and the index.
- R10: Groups with correct odd parity never raise `par_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Bit-clock enable, one bit per pulse |
| in_data | input | 8 | Byte to send |
| in_valid | input | 1 | Byte valid |
| in_last | input | 1 | Byte is the last of the frame |
| in_ready | output | 1 | Byte accepted when high with in_valid |
| tx_bit | output | 1 | Serial bit value |
| tx_kind | output | 2 | 0 start, 1 data, 2 parity, 3 end |
| tx_strobe | output | 1 | tx_bit and tx_kind valid this cycle |
| rx_valid | input | 1 | Received bit valid |
| rx_bit | input | 1 | Received data or parity bit |
| rx_first | input | 1 | This bit is the first data bit of a frame |
| par_err | output | 1 | One-cycle parity error strobe |
| par_err_idx | output | 8 | Byte index of the failing group |

## Verification
Some properties hold on every cycle, and the assertions check those. Every output bit follows an enable. The kind codes only move through legal successions. Each parity bit closes a run of exactly eight data bits and makes that run odd. Every receive error strobe follows a received bit. Other behaviours depend on the values and timing of stimulus, and only the bench scenarios show them: the exact bit order of random frames, the stall when bytes arrive late, the silence while enables are withheld, and which byte indices the receiver reports across frames with injected parity faults.

// File: rtl/pframe_pkg.sv
package pframe_pkg;
    typedef enum logic [1:0] {
        K_START = 2'd0,
        K_DATA  = 2'd1,
        K_PAR   = 2'd2,
        K_END   = 2'd3
    } bit_kind_t;
endpackage

// File: rtl/pframe_odd_par.sv
module pframe_odd_par #(
    parameter int W = 8
) (
    input  logic [W-1:0] data,
    output logic         par
);
    // parity bit that makes data plus parity carry an odd count of ones
    assign par = ~(^data);
endmodule

// File: rtl/pframe_tx.sv
module pframe_tx
    import pframe_pkg::*;
#(
    parameter int   W         = 8,
    parameter logic START_LVL = 1'b1,
    parameter logic END_LVL   = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bit_en,
    input  logic [W-1:0] in_data,
    input  logic         in_valid,
    input  logic         in_last,
    output logic         in_ready,
    output logic         tx_bit,
    output bit_kind_t    tx_kind,
    output logic         tx_strobe
);
    localparam int CW = (W > 1) ? $clog2(W) : 1;

    typedef enum logic [2:0] {
        S_IDLE, S_START, S_DATA, S_PAR, S_STALL, S_END
    } st_t;

    st_t            st_q, st_d;
    logic [W-1:0]   sh_q, sh_d;
    logic           par_q, par_d;
    logic           last_q, last_d;
    logic [CW-1:0]  cnt_q, cnt_d;
    logic           par_new;
    logic           accept;

    pframe_odd_par #(.W(W)) u_par (.data(in_data), .par(par_new));

    always_comb begin
        unique case (st_q)
            S_IDLE, S_STALL: in_ready = 1'b1;
            S_PAR:           in_ready = bit_en & ~last_q;
            default:         in_ready = 1'b0;
        endcase
    end

    assign accept = in_valid & in_ready;

    // next state
    always_comb begin
        st_d   = st_q;
        sh_d   = sh_q;
        par_d  = par_q;
        last_d = last_q;
        cnt_d  = cnt_q;
        unique case (st_q)
            S_IDLE: if (accept) begin
                sh_d   = in_data;
                par_d  = par_new;
                last_d = in_last;
                st_d   = S_START;
            end
            S_START: if (bit_en) begin
                cnt_d = '0;
                st_d  = S_DATA;
            end
            S_DATA: if (bit_en) begin
                sh_d  = sh_q >> 1;
                cnt_d = cnt_q + 1'b1;
                if (cnt_q == CW'(W - 1)) st_d = S_PAR;
            end
            S_PAR: if (bit_en) begin
                if (last_q) begin
                    st_d = S_END;
                end else if (accept) begin
                    sh_d   = in_data;
                    par_d  = par_new;
                    last_d = in_last;
                    cnt_d  = '0;
                    st_d   = S_DATA;
                end else begin
                    st_d = S_STALL;
                end
            end
            S_STALL: if (accept) begin
                sh_d   = in_data;
                par_d  = par_new;
                last_d = in_last;
                cnt_d  = '0;
                st_d   = S_DATA;
            end
            S_END: if (bit_en) st_d = S_IDLE;
            default: st_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= S_IDLE;
            sh_q   <= '0;
            par_q  <= 1'b0;
            last_q <= 1'b0;
            cnt_q  <= '0;
        end else begin
            st_q   <= st_d;
            sh_q   <= sh_d;
            par_q  <= par_d;
            last_q <= last_d;
            cnt_q  <= cnt_d;
        end
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_strobe <= 1'b0;
            tx_bit    <= 1'b0;
            tx_kind   <= K_START;
        end else begin
            tx_strobe <= 1'b0;
            if (bit_en) begin
                unique case (st_q)
                    S_START: begin
                        tx_strobe <= 1'b1;
                        tx_bit    <= START_LVL;
                        tx_kind   <= K_START;
                    end
                    S_DATA: begin
                        tx_strobe <= 1'b1;
                        tx_bit    <= sh_q[0];
                        tx_kind   <= K_DATA;
                    end
                    S_PAR: begin
                        tx_strobe <= 1'b1;
                        tx_bit    <= par_q;
                        tx_kind   <= K_PAR;
                    end
                    S_END: begin
                        tx_strobe <= 1'b1;
                        tx_bit    <= END_LVL;
                        tx_kind   <= K_END;
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/pframe_rx.sv
module pframe_rx #(
    parameter int W     = 8,
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_valid,
    input  logic             rx_bit,
    input  logic             rx_first,
    output logic             par_err,
    output logic [IDX_W-1:0] par_err_idx
);
    localparam int PW = $clog2(W + 1);

    logic [PW-1:0]    pos_q, pos;
    logic [IDX_W-1:0] idx_q, idx_cur;
    logic             acc_q, acc_in, acc_x;

    assign pos     = rx_first ? '0 : pos_q;
    assign idx_cur = rx_first ? '0 : idx_q;
    assign acc_in  = (pos == '0) ? 1'b0 : acc_q;
    assign acc_x   = acc_in ^ rx_bit;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q       <= '0;
            idx_q       <= '0;
            acc_q       <= 1'b0;
            par_err     <= 1'b0;
            par_err_idx <= '0;
        end else begin
            par_err <= 1'b0;
            if (rx_valid) begin
                if (pos == PW'(W)) begin
                    pos_q <= '0;
                    acc_q <= 1'b0;
                    idx_q <= idx_cur + 1'b1;
                    if (!acc_x) begin
                        par_err     <= 1'b1;
                        par_err_idx <= idx_cur;
                    end
                end else begin
                    pos_q <= pos + 1'b1;
                    acc_q <= acc_x;
                    idx_q <= idx_cur;
                end
            end
        end
    end
endmodule

// File: rtl/pframe_codec.sv
module pframe_codec (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_en,
    input  logic [7:0] in_data,
    input  logic       in_valid,
    input  logic       in_last,
    output logic       in_ready,
    output logic       tx_bit,
    output logic [1:0] tx_kind,
    output logic       tx_strobe,
    input  logic       rx_valid,
    input  logic       rx_bit,
    input  logic       rx_first,
    output logic       par_err,
    output logic [7:0] par_err_idx
);
    import pframe_pkg::*;

    bit_kind_t kind_w;

    pframe_tx #(.W(8), .START_LVL(1'b1), .END_LVL(1'b0)) u_tx (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en),
        .in_data(in_data), .in_valid(in_valid), .in_last(in_last),
        .in_ready(in_ready), .tx_bit(tx_bit), .tx_kind(kind_w),
        .tx_strobe(tx_strobe)
    );

    assign tx_kind = kind_w;

    pframe_rx #(.W(8), .IDX_W(8)) u_rx (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_bit(rx_bit),
        .rx_first(rx_first), .par_err(par_err), .par_err_idx(par_err_idx)
    );
endmodule

// File: rtl/pframe_codec_chk.sv
module pframe_codec_chk #(
    parameter int W = 8
) (
    input logic       clk,
    input logic       rst_n,
    input logic       bit_en,
    input logic       tx_bit,
    input logic [1:0] tx_kind,
    input logic       tx_strobe,
    input logic       rx_valid,
    input logic       par_err
);
    localparam int DW = $clog2(W + 1) + 1;

    logic [1:0]    prev_kind_q;
    logic [DW-1:0] dcnt_q;
    logic          acc_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_kind_q <= 2'd3;
            dcnt_q      <= '0;
            acc_q       <= 1'b0;
        end else if (tx_strobe) begin
            prev_kind_q <= tx_kind;
            if (tx_kind == 2'd1) begin
                dcnt_q <= dcnt_q + 1'b1;
                acc_q  <= acc_q ^ tx_bit;
            end else begin
                dcnt_q <= '0;
                acc_q  <= 1'b0;
            end
        end
    end

    assert_strobe_after_en_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_strobe |-> $past(bit_en));

    assert_parity_odd_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_strobe && tx_kind == 2'd2) |-> (dcnt_q == DW'(W) && (acc_q ^ tx_bit)));

    assert_data_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_strobe && tx_kind == 2'd1) |-> (dcnt_q < DW'(W)));

    assert_kind_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_strobe |->
            ((tx_kind == 2'd0 && prev_kind_q == 2'd3) ||
             (tx_kind == 2'd1 && prev_kind_q != 2'd3) ||
             (tx_kind == 2'd2 && prev_kind_q == 2'd1) ||
             (tx_kind == 2'd3 && prev_kind_q == 2'd2)));

    assert_rx_err_follows_bit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        par_err |-> $past(rx_valid));
endmodule

bind pframe_codec pframe_codec_chk #(.W(8)) u_chk (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .tx_bit(tx_bit),
    .tx_kind(tx_kind), .tx_strobe(tx_strobe), .rx_valid(rx_valid),
    .par_err(par_err)
);

// File: tb/pframe_codec_tb.sv
`timescale 1ns/1ps
module pframe_codec_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_en = 1'b0;
    logic [7:0] in_data = '0;
    logic       in_valid = 1'b0;
    logic       in_last = 1'b0;
    logic       in_ready;
    logic       tx_bit;
    logic [1:0] tx_kind;
    logic       tx_strobe;
    logic       rx_valid = 1'b0;
    logic       rx_bit = 1'b0;
    logic       rx_first = 1'b0;
    logic       par_err;
    logic [7:0] par_err_idx;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    int en_div = 1;
    logic hs = 1'b0;

    logic got_b[$];
    logic [1:0] got_k[$];
    logic exp_b[$];
    logic [1:0] exp_k[$];
    int err_q[$];
    int exp_err[$];

    always #5 clk = ~clk;

    pframe_codec u_dut (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .in_data(in_data),
        .in_valid(in_valid), .in_last(in_last), .in_ready(in_ready),
        .tx_bit(tx_bit), .tx_kind(tx_kind), .tx_strobe(tx_strobe),
        .rx_valid(rx_valid), .rx_bit(rx_bit), .rx_first(rx_first),
        .par_err(par_err), .par_err_idx(par_err_idx)
    );

    always @(posedge clk) begin
        hs <= in_valid && in_ready;
        if (en_div <= 0) bit_en <= 1'b0;
        else bit_en <= (($urandom % en_div) == 0);
    end

    always @(negedge clk) begin
        if (tx_strobe) begin
            got_b.push_back(tx_bit);
            got_k.push_back(tx_kind);
        end
        if (par_err) err_q.push_back(int'(par_err_idx));
    end

    function automatic logic odd_bit(input logic [7:0] d);
        return ~(^d);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic send_byte(input logic [7:0] d, input logic last, input int gap);
        repeat (gap) tick();
        in_valid = 1'b1;
        in_data  = d;
        in_last  = last;
        do tick(); while (!hs);
        in_valid = 1'b0;
    endtask

    task automatic expect_frame(input logic [7:0] bytes[$]);
        exp_b.delete();
        exp_k.delete();
        exp_b.push_back(1'b1); exp_k.push_back(2'd0);
        foreach (bytes[j]) begin
            for (int i = 0; i < 8; i++) begin
                exp_b.push_back(bytes[j][i]);
                exp_k.push_back(2'd1);
            end
            exp_b.push_back(odd_bit(bytes[j]));
            exp_k.push_back(2'd2);
        end
        exp_b.push_back(1'b0); exp_k.push_back(2'd3);
    endtask

    task automatic wait_bits(input int n);
        int t = 0;
        while (got_b.size() < n && t < 20000) begin
            tick();
            t++;
        end
        repeat (20) tick();
    endtask

    task automatic compare_frame();
        int bad_d = 0, bad_p = 0, bad_se = 0, bad_k = 0;
        int n;
        check(got_b.size() == exp_b.size(), "R4 frame length", got_b.size(), exp_b.size());
        n = (got_b.size() < exp_b.size()) ? got_b.size() : exp_b.size();
        for (int i = 0; i < n; i++) begin
            if (got_k[i] != exp_k[i]) bad_k++;
            else if (got_b[i] != exp_b[i]) begin
                if (exp_k[i] == 2'd1) bad_d++;
                else if (exp_k[i] == 2'd2) bad_p++;
                else bad_se++;
            end
        end
        check(bad_k == 0, "R5 kind sequence mismatches", bad_k, 0);
        check(bad_d == 0, "R2 data bit mismatches", bad_d, 0);
        check(bad_p == 0, "R3 parity bit mismatches", bad_p, 0);
        check(bad_se == 0, "R4 start/end mismatches", bad_se, 0);
    endtask

    task automatic run_frame(input int nbytes, input int gapmax);
        logic [7:0] bytes[$];
        for (int j = 0; j < nbytes; j++) bytes.push_back(8'($urandom));
        expect_frame(bytes);
        got_b.delete();
        got_k.delete();
        foreach (bytes[j])
            send_byte(bytes[j], j == nbytes - 1, int'($urandom % (gapmax + 1)));
        wait_bits(exp_b.size());
        compare_frame();
    endtask

    task automatic rx_group(input logic [7:0] d, input logic flip, input logic first, input int gapmax);
        for (int i = 0; i < 9; i++) begin
            rx_valid = 1'b0;
            repeat ($urandom % (gapmax + 1)) tick();
            rx_valid = 1'b1;
            rx_bit   = (i < 8) ? d[i] : (odd_bit(d) ^ flip);
            rx_first = first && (i == 0);
            tick();
        end
        rx_valid = 1'b0;
        rx_first = 1'b0;
    endtask

    task automatic compare_errs(input string req);
        repeat (3) tick();
        check(err_q.size() == exp_err.size(), req, err_q.size(), exp_err.size());
        if (err_q.size() == exp_err.size())
            foreach (exp_err[i])
                check(err_q[i] == exp_err[i], req, err_q[i], exp_err[i]);
        err_q.delete();
        exp_err.delete();
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] fb[$];
        void'($urandom(32'd2024));
        en_div = 1;
        repeat (4) tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state
        check(in_ready == 1'b1, "R1 in_ready after reset", in_ready, 1);
        check(tx_strobe == 1'b0, "R1 tx_strobe after reset", tx_strobe, 0);
        check(par_err == 1'b0, "R1 par_err after reset", par_err, 0);

        // R3 directed: 0x60 single byte frame, parity 1
        fb.delete(); fb.push_back(8'h60);
        expect_frame(fb);
        got_b.delete(); got_k.delete();
        send_byte(8'h60, 1'b1, 0);
        wait_bits(exp_b.size());
        compare_frame();
        check(got_b.size() > 9 && got_b[9] == 1'b1, "R3 parity of 0x60", got_b.size() > 9 ? got_b[9] : 0, 1);

        // R6: no bits while enables are withheld; R8 ready low in start
        en_div = 0;
        got_b.delete(); got_k.delete();
        fb.delete(); fb.push_back(8'hA5);
        expect_frame(fb);
        send_byte(8'hA5, 1'b1, 0);
        repeat (30) tick();
        check(got_b.size() == 0, "R6 bits without enable", got_b.size(), 0);
        check(in_ready == 1'b0, "R8 ready while start pending", in_ready, 0);
        en_div = 1;
        wait_bits(exp_b.size());
        compare_frame();

        // R7 stall between bytes, R8 ready while stalled
        got_b.delete(); got_k.delete();
        send_byte(8'h60, 1'b0, 0);
        repeat (60) tick();
        check(got_b.size() == 10, "R7 bits emitted before stall", got_b.size(), 10);
        check(in_ready == 1'b1, "R8 ready while stalled", in_ready, 1);
        send_byte(8'h01, 1'b1, 0);
        wait_bits(20);
        fb.delete(); fb.push_back(8'h60); fb.push_back(8'h01);
        expect_frame(fb);
        compare_frame();
        check(got_k.size() == 20 && got_k[19] == 2'd3, "R7 end after resumed last byte",
              got_k.size(), 20);

        // R5 back-to-back long frame with full-rate enables
        en_div = 1;
        run_frame(6, 0);

        // random frames
        for (int f = 0; f < 8; f++) begin
            en_div = 1 + int'($urandom % 3);
            run_frame(1 + int'($urandom % 6), int'($urandom % 5));
        end
        en_div = 1;

        // R9 directed receive errors
        rx_group(8'h60, 1'b0, 1'b1, 0);
        rx_group(8'hA5, 1'b1, 1'b0, 0);
        rx_group(8'h00, 1'b0, 1'b0, 1);
        rx_group(8'hFF, 1'b1, 1'b0, 2);
        exp_err.push_back(1); exp_err.push_back(3);
        compare_errs("R9 directed error indices");

        // R9 restart with rx_first
        rx_group(8'h3C, 1'b1, 1'b1, 0);
        exp_err.push_back(0);
        compare_errs("R9 index restart on first bit");

        // R10 clean frame
        for (int j = 0; j < 5; j++) rx_group(8'($urandom), 1'b0, j == 0, 2);
        compare_errs("R10 clean frame no errors");

        // random receive frames
        for (int f = 0; f < 3; f++) begin
            for (int j = 0; j < 6; j++) begin
                logic fl;
                fl = ($urandom % 3) == 0;
                if (fl) exp_err.push_back(j);
                rx_group(8'($urandom), fl, j == 0, 2);
            end
            compare_errs("R9 random error indices");
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule